// File: doc/BRIEF.md
# Host Mailbox Interrupt Controller

This block is the interrupt logic between an external host and a local processor that talk through four byte-wide mailbox channels. In the host-to-local direction, the host writes a byte into a channel's input data register. That sets the channel's full flag, and the channel raises a buffer-full interrupt to the local processor if its enable bit is set. The local processor empties the channel by reading the register. In the local-to-host direction, firmware writes a five-bit host request register. Each bit drives one host interrupt pin when the pin's direction bit selects output. The host acknowledges implicitly: reading a channel's output data register clears the request bits owned by that channel. Channel 1 owns two bits, and channels 2, 3 and 4 own one bit each.

The host strobes are asynchronous to the local clock. The read strobe, write strobe, address bit 0 and the four chip selects pass through a two-flop synchroniser. A host access state machine then turns each strobe into a single action. Its states are `HS_IDLE`, `HS_READ` and `HS_WRITE`. Its transitions are:
- IDLE→READ when the synchronised read strobe is low. This emits one clear pulse per selected channel when address bit 0 is low.
- IDLE→WRITE when the write strobe is low and the read strobe is high. This emits one load pulse per selected channel when address bit 0 is low.
- READ→IDLE and WRITE→IDLE when the strobe returns high.

The host data bus is captured while the write strobe is held.

Top module: `hmbx_irq`

## Requirements
- R1: After reset, all of the following are 0: every full flag, enable bit, request bit and direction bit, `ibf_irq`, and `host_irq`.
- R2: A host write with `hb_cs_n[i]`=0 and `hb_a0`=0 loads `hb_din` into channel i's input register and sets its full flag. A host write with `hb_a0`=1 changes nothing. The full flags read back at local address 11, bits [3:0], with bit i for channel i.
- R3: `ibf_irq[i]` is 1 exactly when channel i is full and enable bit i is 1. The enable bits are at local address 8, bits [3:0].
- R4: A local read of address i (0..3) returns channel i's input register and clears its full flag.
- R5: A local write to address 9 loads `lb_wdata[4:0]` into the request bits, which read back at the same address. Bits 0 and 1 belong to channel 0 (the first channel), bit 2 to channel 1, bit 3 to channel 2, and bit 4 to channel 3.
- R6: `host_irq[k]` equals request bit k AND direction bit k. The direction bits are at local address 10, bits [4:0].
- R7: A host read with `hb_cs_n[i]`=0 and `hb_a0`=0 clears the request bits that channel i owns. For channel 0 this is both bit 0 and bit 1. A host read with `hb_a0`=1 clears nothing.
- R8: Each host read access clears its request bits once only. Bits set again by firmware while the read strobe is still low stay set.
- R9: When a firmware write to address 9 and a host-read clear happen in the same cycle, the written value is loaded.
- R10: Local writes to addresses 4..7 load the output registers of channels 0..3. `hb_dout` shows the output register of the lowest-numbered channel whose chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lb_wr | input | 1 | Local bus write strobe |
| lb_rd | input | 1 | Local bus read strobe |
| lb_addr | input | 4 | Local bus register address |
| lb_wdata | input | 8 | Local bus write data |
| lb_rdata | output | 8 | Local bus read data |
| hb_cs_n | input | 4 | Host chip selects, active low, one per channel |
| hb_a0 | input | 1 | Host address bit 0 |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_din | input | 8 | Host write data |
| hb_dout | output | 8 | Host read data (selected output register) |
| ibf_irq | output | 4 | Buffer-full interrupts to local processor |
| host_irq | output | 5 | Host interrupt request pins |

## Verification
The bench sweeps every request pattern against a host read of every channel. This would catch a wrong latch-to-channel mapping: for example, a channel-0 read that cleared only one of its two bits, or a read that cleared a neighbour's bit. It sweeps all enable and fill combinations of the four channels. It also drives host reads and writes with address bit 0 high, which a design decoding the address loosely would wrongly act on.

Two cases are aimed at timing. In the first, firmware re-sets the bits while the read strobe is still low; a level-sensitive clear would wipe them again. In the second, firmware writes in exactly the cycle of the clear; a clear-priority design would lose that request.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    localparam int NCH   = 4;
    localparam int NLAT  = 5;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int SYNCW = NCH + 3;

    localparam logic [AW-1:0] ADDR_IDR0  = 4'd0;
    localparam logic [AW-1:0] ADDR_ODR0  = 4'd4;
    localparam logic [AW-1:0] ADDR_IBFEN = 4'd8;
    localparam logic [AW-1:0] ADDR_LATCH = 4'd9;
    localparam logic [AW-1:0] ADDR_DIR   = 4'd10;
    localparam logic [AW-1:0] ADDR_FULL  = 4'd11;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_READ  = 2'd1,
        HS_WRITE = 2'd2
    } hs_state_t;

    // Request bits owned by a channel: channel 0 owns two.
    function automatic logic [NLAT-1:0] chan_mask(input int ch);
        logic [NLAT-1:0] m;
        m = '0;
        if (ch == 0) m[1:0] = 2'b11;
        else         m[ch+1] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hmbx_host_fsm.sv
module hmbx_host_fsm
    import hmbx_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_s_n,
    input  logic           wr_s_n,
    input  logic           a0_s,
    input  logic [NCH-1:0] cs_s_n,
    output logic [NCH-1:0] rd_hit,
    output logic [NCH-1:0] wr_hit
);
    hs_state_t state_q, state_d;
    logic [NCH-1:0] sel;

    assign sel = ~cs_s_n & {NCH{~a0_s}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rd_hit  = '0;
        wr_hit  = '0;
        unique case (state_q)
            HS_IDLE: begin
                if (!rd_s_n) begin
                    rd_hit  = sel;
                    state_d = HS_READ;
                end else if (!wr_s_n) begin
                    wr_hit  = sel;
                    state_d = HS_WRITE;
                end
            end
            HS_READ:  if (rd_s_n) state_d = HS_IDLE;
            HS_WRITE: if (wr_s_n) state_d = HS_IDLE;
            default:  state_d = HS_IDLE;
        endcase
    end
endmodule

// File: rtl/hmbx_ibf_chan.sv
module hmbx_ibf_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          drain,
    input  logic          enable,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
        end else if (load) begin
            data <= din;
            full <= 1'b1;
        end else if (drain) begin
            full <= 1'b0;
        end
    end

    assign irq = full & enable;
endmodule

// File: rtl/hmbx_irq.sv
module hmbx_irq
    import hmbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lb_wr,
    input  logic            lb_rd,
    input  logic [AW-1:0]   lb_addr,
    input  logic [DW-1:0]   lb_wdata,
    output logic [DW-1:0]   lb_rdata,
    input  logic [NCH-1:0]  hb_cs_n,
    input  logic            hb_a0,
    input  logic            hb_rd_n,
    input  logic            hb_wr_n,
    input  logic [DW-1:0]   hb_din,
    output logic [DW-1:0]   hb_dout,
    output logic [NCH-1:0]  ibf_irq,
    output logic [NLAT-1:0] host_irq
);
    logic [SYNCW-1:0] raw_ctl, syn_ctl;
    logic [NCH-1:0]   rd_hit, wr_hit, drain, full;
    logic [NCH-1:0]   ibf_en_q;
    logic [NLAT-1:0]  latch_q, dir_q, clr_mask;
    logic [DW-1:0]    idr   [NCH];
    logic [DW-1:0]    odr_q [NCH];

    assign raw_ctl = {hb_rd_n, hb_wr_n, hb_a0, hb_cs_n};

    hmbx_sync #(.W(SYNCW), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(syn_ctl)
    );

    hmbx_host_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_s_n (syn_ctl[NCH+2]),
        .wr_s_n (syn_ctl[NCH+1]),
        .a0_s   (syn_ctl[NCH]),
        .cs_s_n (syn_ctl[NCH-1:0]),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign drain[c] = lb_rd && (lb_addr == ADDR_IDR0 + AW'(c));

        hmbx_ibf_chan #(.DW(DW)) u_ibf (
            .clk(clk), .rst_n(rst_n), .load(wr_hit[c]), .din(hb_din),
            .drain(drain[c]), .enable(ibf_en_q[c]), .data(idr[c]),
            .full(full[c]), .irq(ibf_irq[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                odr_q[c] <= '0;
            else if (lb_wr && lb_addr == ADDR_ODR0 + AW'(c))
                odr_q[c] <= lb_wdata;
        end
    end

    always_comb begin
        clr_mask = '0;
        for (int c = 0; c < NCH; c++)
            if (rd_hit[c]) clr_mask |= chan_mask(c);
    end

    // Firmware write takes precedence over a host-read clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            dir_q    <= '0;
            ibf_en_q <= '0;
        end else begin
            if (lb_wr && lb_addr == ADDR_LATCH) latch_q <= lb_wdata[NLAT-1:0];
            else                                latch_q <= latch_q & ~clr_mask;
            if (lb_wr && lb_addr == ADDR_DIR)   dir_q    <= lb_wdata[NLAT-1:0];
            if (lb_wr && lb_addr == ADDR_IBFEN) ibf_en_q <= lb_wdata[NCH-1:0];
        end
    end

    assign host_irq = latch_q & dir_q;

    always_comb begin
        hb_dout = '0;
        for (int c = NCH - 1; c >= 0; c--)
            if (!hb_cs_n[c]) hb_dout = odr_q[c];
    end

    always_comb begin
        lb_rdata = '0;
        case (lb_addr)
            ADDR_IBFEN: lb_rdata = DW'(ibf_en_q);
            ADDR_LATCH: lb_rdata = DW'(latch_q);
            ADDR_DIR:   lb_rdata = DW'(dir_q);
            ADDR_FULL:  lb_rdata = DW'(full);
            default: begin
                for (int c = 0; c < NCH; c++) begin
                    if (lb_addr == ADDR_IDR0 + AW'(c)) lb_rdata = idr[c];
                    if (lb_addr == ADDR_ODR0 + AW'(c)) lb_rdata = odr_q[c];
                end
            end
        endcase
    end
endmodule

// File: rtl/hmbx_irq_chk.sv
module hmbx_irq_chk
    import hmbx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lb_wr,
    input logic [AW-1:0]   lb_addr,
    input logic [DW-1:0]   lb_wdata,
    input logic [NCH-1:0]  ibf_irq,
    input logic [NLAT-1:0] host_irq,
    input logic [NCH-1:0]  ibf_en_q,
    input logic [NLAT-1:0] latch_q,
    input logic [NLAT-1:0] dir_q,
    input logic [NCH-1:0]  rd_hit,
    input logic [NCH-1:0]  wr_hit,
    input logic [NCH-1:0]  full
);
    logic fw_latch_wr;
    assign fw_latch_wr = lb_wr && (lb_addr == ADDR_LATCH);

    AST_FULL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit != '0) |=> ((full & $past(wr_hit)) == $past(wr_hit))); // R2
    AST_IBF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((ibf_irq & ~ibf_en_q) == '0)); // R3
    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_irq & ~dir_q) == '0)); // R6
    AST_CH0_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[0] && !fw_latch_wr) |=> (latch_q[1:0] == 2'b00)); // R7
    AST_CLEAR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit != '0) |=> (rd_hit == '0)); // R8
    AST_FW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fw_latch_wr |=> (latch_q == $past(lb_wdata[NLAT-1:0]))); // R9
endmodule

bind hmbx_irq hmbx_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lb_wr(lb_wr), .lb_addr(lb_addr),
    .lb_wdata(lb_wdata), .ibf_irq(ibf_irq), .host_irq(host_irq),
    .ibf_en_q(ibf_en_q), .latch_q(latch_q), .dir_q(dir_q),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .full(full)
);

// File: tb/hmbx_irq_bench.sv
module hmbx_irq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lb_wr = 1'b0, lb_rd = 1'b0;
    logic [3:0] lb_addr = '0;
    logic [7:0] lb_wdata = '0, lb_rdata;
    logic [3:0] hb_cs_n = 4'hF;
    logic       hb_a0 = 1'b0, hb_rd_n = 1'b1, hb_wr_n = 1'b1;
    logic [7:0] hb_din = '0, hb_dout;
    logic [3:0] ibf_irq;
    logic [4:0] host_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmbx_irq u_hmbx_irq (
        .clk(clk), .rst_n(rst_n), .lb_wr(lb_wr), .lb_rd(lb_rd),
        .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .hb_cs_n(hb_cs_n), .hb_a0(hb_a0), .hb_rd_n(hb_rd_n),
        .hb_wr_n(hb_wr_n), .hb_din(hb_din), .hb_dout(hb_dout),
        .ibf_irq(ibf_irq), .host_irq(host_irq)
    );

    function automatic logic [4:0] own_mask(input int ch);
        return (ch == 0) ? 5'b00011 : 5'(1 << (ch + 1));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lb_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        lb_wr = 1'b1; lb_addr = a; lb_wdata = d;
        @(negedge clk);
        lb_wr = 1'b0;
    endtask

    task automatic lb_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        lb_rd = 1'b1; lb_addr = a;
        #1 d = lb_rdata;
        @(negedge clk);
        lb_rd = 1'b0;
    endtask

    task automatic host_read(input int ch, input logic a0, output logic [7:0] d);
        @(negedge clk);
        hb_cs_n = ~(4'(1 << ch)); hb_a0 = a0; hb_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = hb_dout;
        hb_rd_n = 1'b1;
        @(negedge clk);
        hb_cs_n = 4'hF; hb_a0 = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_write(input int ch, input logic a0, input logic [7:0] d);
        @(negedge clk);
        hb_cs_n = ~(4'(1 << ch)); hb_a0 = a0; hb_din = d; hb_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        hb_wr_n = 1'b1;
        @(negedge clk);
        hb_cs_n = 4'hF; hb_a0 = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ibf_irq", int'(ibf_irq), 0);
        check("R1 host_irq", int'(host_irq), 0);
        for (int a = 8; a < 12; a++) begin
            lb_read(4'(a), d);
            check("R1 reg", int'(d), 0);
        end

        // R10 output registers seen by host
        for (int ch = 0; ch < 4; ch++) lb_write(4'(4 + ch), 8'hA0 + 8'(ch * 17));
        for (int ch = 0; ch < 4; ch++) begin
            host_read(ch, 1'b0, d);
            check("R10 hb_dout", int'(d), int'(8'hA0 + 8'(ch * 17)));
        end
        @(negedge clk);
        hb_cs_n = 4'b0110; #1;
        check("R10 lowest cs", int'(hb_dout), int'(8'hA0));
        hb_cs_n = 4'b1011; #1;
        check("R10 single cs", int'(hb_dout), int'(8'hA0 + 8'd34));
        hb_cs_n = 4'hF;

        // R5 / R7 sweep of every pattern against every channel
        lb_write(4'd10, 8'h1F);
        for (int ch = 0; ch < 4; ch++) begin
            for (int pat = 0; pat < 32; pat++) begin
                lb_write(4'd9, 8'(pat));
                lb_read(4'd9, d);
                check("R5 readback", int'(d), pat);
                check("R5 pins", int'(host_irq), pat);
                host_read(ch, 1'b0, d);
                check("R7 clear map", int'(host_irq), pat & ~int'(own_mask(ch)));
            end
        end

        // R7 a0 high reads clear nothing
        lb_write(4'd9, 8'h1F);
        for (int ch = 0; ch < 4; ch++) begin
            host_read(ch, 1'b1, d);
            check("R7 a0 read", int'(host_irq), 31);
        end

        // R6 direction gating
        for (int dv = 0; dv < 32; dv++) begin
            lb_write(4'd10, 8'(dv));
            check("R6 pins", int'(host_irq), dv);
        end
        lb_write(4'd9, 8'h0A);
        check("R6 mixed", int'(host_irq), 8'h0A & 8'h1F);
        lb_write(4'd10, 8'h03);
        check("R6 mixed dir", int'(host_irq), 2);

        // R2 / R3 / R4 sweep of enables and fill patterns
        for (int en = 0; en < 16; en++) begin
            lb_write(4'd8, 8'(en));
            for (int pat = 0; pat < 16; pat++) begin
                for (int ch = 0; ch < 4; ch++)
                    if (pat[ch]) host_write(ch, 1'b0, 8'(pat * 16 + ch));
                check("R3 ibf_irq", int'(ibf_irq), en & pat);
                lb_read(4'd11, d);
                check("R2 full flags", int'(d), pat);
                for (int ch = 0; ch < 4; ch++)
                    if (pat[ch]) begin
                        lb_read(4'(ch), d);
                        check("R4 idr data", int'(d), (pat * 16 + ch) & 255);
                    end
                @(negedge clk);
                check("R4 drained irq", int'(ibf_irq), 0);
                lb_read(4'd11, d);
                check("R4 drained flags", int'(d), 0);
            end
        end

        // R2 a0 high writes ignored
        for (int ch = 0; ch < 4; ch++) host_write(ch, 1'b1, 8'h55);
        lb_read(4'd11, d);
        check("R2 a0 write", int'(d), 0);
        check("R2 a0 irq", int'(ibf_irq), 0);

        // R8 re-set while read strobe held
        lb_write(4'd10, 8'h1F);
        lb_write(4'd9, 8'h1F);
        @(negedge clk);
        hb_cs_n = 4'b1101; hb_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 first clear", int'(host_irq), 5'b11011);
        lb_write(4'd9, 8'h1F);
        repeat (4) @(negedge clk);
        check("R8 no second clear", int'(host_irq), 31);
        hb_rd_n = 1'b1;
        @(negedge clk);
        hb_cs_n = 4'hF;
        repeat (4) @(negedge clk);

        // R9 write in the clear cycle: rd low before edge 1, clear at edge 3
        @(negedge clk);
        hb_cs_n = 4'b1110; hb_rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        lb_wr = 1'b1; lb_addr = 4'd9; lb_wdata = 8'h17;
        @(negedge clk);
        lb_wr = 1'b0;
        check("R9 write wins", int'(host_irq), 8'h17);
        hb_rd_n = 1'b1;
        @(negedge clk);
        hb_cs_n = 4'hF;
        repeat (4) @(negedge clk);
        check("R9 stays", int'(host_irq), 8'h17);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule